// File: doc/BRIEF.md
# LCD Controller Mode Register and DMA Request Logic

This block holds the main 32-bit mode register of a small LCD controller, plus the logic that depends directly on it. Software writes and reads the register over a simple register port; the block then turns those settings into the panel power pin, the bus-request line for the pixel DMA, a selectable vertical-timing interrupt and a gate on direct test access to the DMA FIFO storage.

The DMA request is formed from the empty-slot counts of two pixel FIFOs against a threshold of 4 or 8 that software picks. The interrupt is raised on the rising edge of one of four vertical-phase indicators from the timing generator, is held until cleared, and is masked at the output. The timing generator, the FIFOs and the pixel pipeline sit outside; they appear here only as phase inputs, count inputs and test-access strobes.

Top module: `lcdc_ctrl_top`

## Requirements
- R1: After reset the register reads 0, `panel_pwr` is low, `irq_out` is low and `dma_req` is low.
- R2: Bits 31:17, 14, 10 and 9 are reserved: writing 1 to them has no effect and they always read 0.
- R3: The register answers only at byte offset 0x1C; a write to any other offset changes nothing, and a read at any other offset returns 0. Writable bits at 0x1C read back as written, except as R7 states.
- R4: With bit 16 = 0 and the block enabled (bit 0 = 1, bit 15 = 0), `dma_req` is high exactly when either FIFO count is 4 or more.
- R5: With bit 16 = 1 and the block enabled, `dma_req` is high exactly when either FIFO count is 8 or more.
- R6: `dma_req` is low whenever bit 0 = 0 or bit 15 = 1, whatever the FIFO counts.
- R7: Bit 15 (FIFO test mode) is stored only from a write whose bit 0 is 0; a write with bit 0 = 1 leaves bit 15 at 0, so test mode and enable are never both set.
- R8: `test_wr_ok` / `test_rd_ok` follow `test_wr_req` / `test_rd_req` only while bit 15 = 1 and bit 0 = 0; otherwise they are low.
- R9: Bits 13:12 pick the interrupt event from `vphase`: 00 = bit 0 (sync start), 01 = bit 1 (back porch start), 10 = bit 2 (active start), 11 = bit 3 (front porch start); only a 0-to-1 change of the picked bit sets the pending flag, and the flag is visible one clock edge later.
- R10: The pending flag stays set until `irq_clr` is high at a clock edge; if a new event and a clear meet at the same edge, the flag stays set.
- R11: `irq_out` is the pending flag ANDed with `irq_mask`.
- R12: `panel_pwr` is high only when bit 11 = 1 and bit 0 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| fifo_a_free | input | 5 | Empty slots in DMA FIFO A |
| fifo_b_free | input | 5 | Empty slots in DMA FIFO B |
| dma_req | output | 1 | Bus request for pixel DMA |
| vphase | input | 4 | Vertical phase indicators (sync, back porch, active, front porch) |
| irq_clr | input | 1 | Clears the pending interrupt flag |
| irq_mask | input | 1 | Interrupt output enable |
| irq_out | output | 1 | Masked vertical compare interrupt |
| panel_pwr | output | 1 | Panel power enable pin |
| panel_fmt | output | 8 | Stored panel format bits 8:1 for the pixel path |
| test_wr_req | input | 1 | FIFO test write strobe |
| test_rd_req | input | 1 | FIFO test read strobe |
| test_wr_ok | output | 1 | Granted FIFO test write |
| test_rd_ok | output | 1 | Granted FIFO test read |

## Verification
Every cycle, the assertions hold the invariants that need no history of stimulus: no bus request while disabled or in test mode, a request whenever any count reaches the high mark while running, test mode never coexisting with enable, test grants only in test mode, power only with enable, reserved read bits at zero, and the pending flag following its event and clear. The bench's scenarios are what show the selection itself: that each phase code picks the right indicator and ignores the other three, that a held level does not re-arm the flag, the exact 3/4 and 7/8 threshold boundaries, address decode and readback values, and the behaviour from reset.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int REG_W = 32;

  // bit positions of the mode register
  localparam int B_EN    = 0;
  localparam int B_FMT_L = 1;
  localparam int B_FMT_H = 8;
  localparam int B_PWR   = 11;
  localparam int B_VS_L  = 12;
  localparam int B_VS_H  = 13;
  localparam int B_TEST  = 15;
  localparam int B_WM    = 16;

  // writable bits: 16, 15, 13:11, 8:0
  localparam logic [REG_W-1:0] WR_MASK = 32'h0001_B9FF;

  // request threshold picked by the watermark bit
  function automatic int unsigned thr_of(input logic wm, input int unsigned lo,
                                         input int unsigned hi);
    return wm ? hi : lo;
  endfunction

  // stored test bit: only a write that leaves the block disabled may set it
  function automatic logic test_next(input logic [REG_W-1:0] wd);
    return wd[B_TEST] & ~wd[B_EN];
  endfunction
endpackage

// File: rtl/lcdc_ctrl_regs.sv
module lcdc_ctrl_regs
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              en,
  output logic              test,
  output logic              wm,
  output logic              pwr,
  output logic [1:0]        vsel,
  output logic [B_FMT_H-B_FMT_L:0] fmt
);
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] ctrl_d;
  logic             hit;

  assign hit = (addr == REG_OFS);

  always_comb begin
    ctrl_d         = wdata & WR_MASK;
    ctrl_d[B_TEST] = test_next(wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (wr && hit)  ctrl_q <= ctrl_d;
  end

  assign rdata = hit ? ctrl_q : '0;
  assign en    = ctrl_q[B_EN];
  assign test  = ctrl_q[B_TEST];
  assign wm    = ctrl_q[B_WM];
  assign pwr   = ctrl_q[B_PWR];
  assign vsel  = ctrl_q[B_VS_H:B_VS_L];
  assign fmt   = ctrl_q[B_FMT_H:B_FMT_L];

  // R7
  test_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test |-> !en);
  // R3
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> $stable(ctrl_q));
endmodule

// File: rtl/lcdc_dma_req.sv
module lcdc_dma_req
  import lcdc_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int LO_MARK = 4,
  parameter int HI_MARK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             test,
  input  logic             wm,
  input  logic [CNT_W-1:0] free_a,
  input  logic [CNT_W-1:0] free_b,
  output logic             req
);
  localparam int unsigned LO_U = LO_MARK;
  localparam int unsigned HI_U = HI_MARK;

  logic [CNT_W:0] thr;
  logic           a_hit, b_hit, run;

  assign thr   = (CNT_W+1)'(thr_of(wm, LO_U, HI_U));
  assign a_hit = {1'b0, free_a} >= thr;
  assign b_hit = {1'b0, free_b} >= thr;
  assign run   = en & ~test;
  assign req   = run & (a_hit | b_hit);

  // R5
  hi_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !test && (32'(free_a) >= HI_MARK || 32'(free_b) >= HI_MARK)) |-> req);
  // R4
  below_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_a) < LO_MARK && 32'(free_b) < LO_MARK) |-> !req);
endmodule

// File: rtl/lcdc_vcmp_irq.sv
module lcdc_vcmp_irq #(
  parameter int N_PH = 4,
  localparam int SEL_W = $clog2(N_PH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PH-1:0]  phase,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  input  logic             mask,
  output logic             irq,
  output logic             pend
);
  logic [N_PH-1:0] prev_q;
  logic [N_PH-1:0] rise;
  logic            evt;
  logic            pend_q;

  for (genvar i = 0; i < N_PH; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= phase[i];
    end
    assign rise[i] = phase[i] & ~prev_q[i];
  end

  assign evt = rise[sel];

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (evt) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign pend = pend_q;
  assign irq  = pend_q & mask;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_q);
  // R10
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !pend_q);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !evt) |=> !pend_q);
endmodule

// File: rtl/lcdc_ctrl_top.sv
module lcdc_ctrl_top
  import lcdc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int LO_MARK    = 4,
  parameter int HI_MARK    = 8,
  parameter int N_PH       = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CNT_W-1:0]  fifo_a_free,
  input  logic [CNT_W-1:0]  fifo_b_free,
  output logic              dma_req,
  input  logic [N_PH-1:0]   vphase,
  input  logic              irq_clr,
  input  logic              irq_mask,
  output logic              irq_out,
  output logic              panel_pwr,
  output logic [7:0]        panel_fmt,
  input  logic              test_wr_req,
  input  logic              test_rd_req,
  output logic              test_wr_ok,
  output logic              test_rd_ok
);
  logic       en, test, wm, pwr, pend;
  logic [1:0] vsel;

  lcdc_ctrl_regs #(.ADDR_W(ADDR_W), .REG_OFS(ADDR_W'(8'h1C))) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en(en), .test(test), .wm(wm), .pwr(pwr),
    .vsel(vsel), .fmt(panel_fmt)
  );

  lcdc_dma_req #(.CNT_W(CNT_W), .LO_MARK(LO_MARK), .HI_MARK(HI_MARK)) u_dma (
    .clk(clk), .rst_n(rst_n), .en(en), .test(test), .wm(wm),
    .free_a(fifo_a_free), .free_b(fifo_b_free), .req(dma_req)
  );

  lcdc_vcmp_irq #(.N_PH(N_PH)) u_irq (
    .clk(clk), .rst_n(rst_n), .phase(vphase), .sel(vsel[$clog2(N_PH)-1:0]),
    .clr(irq_clr), .mask(irq_mask), .irq(irq_out), .pend(pend)
  );

  // panel power and test-access gating
  logic test_gate;
  assign test_gate  = test & ~en;
  assign test_wr_ok = test_wr_req & test_gate;
  assign test_rd_ok = test_rd_req & test_gate;
  assign panel_pwr  = pwr & en;

  // R6
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || test) |-> !dma_req);
  // R12
  pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_pwr |-> (pwr && en));
  // R8
  test_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_wr_ok || test_rd_ok) |-> (test && !en));
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~WR_MASK) == 32'h0);
  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend && irq_mask));
endmodule

// File: tb/sim_lcdc_ctrl_top.sv
module sim_lcdc_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h1C;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  fifo_a_free = '0;
  logic [4:0]  fifo_b_free = '0;
  logic        dma_req;
  logic [3:0]  vphase = '0;
  logic        irq_clr = 1'b0;
  logic        irq_mask = 1'b1;
  logic        irq_out;
  logic        panel_pwr;
  logic [7:0]  panel_fmt;
  logic        test_wr_req = 1'b0;
  logic        test_rd_req = 1'b0;
  logic        test_wr_ok;
  logic        test_rd_ok;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lcdc_ctrl_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_a_free(fifo_a_free),
    .fifo_b_free(fifo_b_free), .dma_req(dma_req), .vphase(vphase),
    .irq_clr(irq_clr), .irq_mask(irq_mask), .irq_out(irq_out),
    .panel_pwr(panel_pwr), .panel_fmt(panel_fmt), .test_wr_req(test_wr_req),
    .test_rd_req(test_rd_req), .test_wr_ok(test_wr_ok), .test_rd_ok(test_rd_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h1C;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 8'h1C; #1;
  endtask

  task automatic counts(input int a, input int b);
    fifo_a_free = 5'(a); fifo_b_free = 5'(b); #1;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0; #1;
  endtask

  // rising edge on one phase bit, held for one cycle
  task automatic pulse(input int i);
    @(negedge clk); vphase[i] = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); vphase[i] = 1'b0; #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    counts(16, 16);
    rd(8'h1C, d);
    chk("R1 rdata", d, 32'h0);
    chk("R1 pwr", 32'(panel_pwr), 0);
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 dma", 32'(dma_req), 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d);
    chk("R2 all-ones write", d, 32'h0001_39FF);
    chk("R2 reserved zero", d & ~32'h0001_B9FF, 32'h0);
    chk("R3 fmt field", 32'(panel_fmt), 32'hFF);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h0000_0801);
    rd(8'h1C, d);
    chk("R3 miss write ignored", d, 32'h0);
    chk("R3 miss write no power", 32'(panel_pwr), 0);
    wr(8'h1C, 32'h0000_3A5);
    rd(8'h20, d);
    chk("R3 other offset reads 0", d, 32'h0);
    rd(8'h1C, d);
    chk("R3 readback", d, 32'h0000_03A5 & 32'h0001_B9FF);
  endtask

  task automatic t_watermark();
    wr(8'h1C, 32'h0000_0001);
    counts(3, 3);  chk("R4 3/3 low", 32'(dma_req), 0);
    counts(4, 0);  chk("R4 a=4 high", 32'(dma_req), 1);
    counts(3, 5);  chk("R4 b=5 high", 32'(dma_req), 1);
    wr(8'h1C, 32'h0001_0001);
    counts(7, 7);  chk("R5 7/7 low", 32'(dma_req), 0);
    counts(2, 8);  chk("R5 b=8 high", 32'(dma_req), 1);
    counts(16, 0); chk("R5 a=16 high", 32'(dma_req), 1);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    counts(16, 16);
    wr(8'h1C, 32'h0001_0000);
    chk("R6 disabled", 32'(dma_req), 0);
    wr(8'h1C, 32'h0000_8000);
    rd(8'h1C, d);
    chk("R7 test stored", d, 32'h0000_8000);
    chk("R6 test mode", 32'(dma_req), 0);
    wr(8'h1C, 32'h0000_8001);
    rd(8'h1C, d);
    chk("R7 test blocked with enable", d, 32'h0000_0001);
    chk("R6 running", 32'(dma_req), 1);
  endtask

  task automatic t_test();
    test_wr_req = 1'b1; test_rd_req = 1'b1;
    wr(8'h1C, 32'h0000_8000);
    chk("R8 wr granted", 32'(test_wr_ok), 1);
    chk("R8 rd granted", 32'(test_rd_ok), 1);
    wr(8'h1C, 32'h0);
    chk("R8 no test mode", 32'(test_wr_ok | test_rd_ok), 0);
    wr(8'h1C, 32'h0000_8001);
    chk("R8 enabled blocks", 32'(test_wr_ok | test_rd_ok), 0);
    test_wr_req = 1'b0; test_rd_req = 1'b0;
  endtask

  task automatic t_power();
    wr(8'h1C, 32'h0000_0800); chk("R12 pwr w/o en", 32'(panel_pwr), 0);
    wr(8'h1C, 32'h0000_0801); chk("R12 pwr on", 32'(panel_pwr), 1);
    wr(8'h1C, 32'h0000_0001); chk("R12 pwr off", 32'(panel_pwr), 0);
  endtask

  task automatic t_select();
    irq_mask = 1'b1;
    for (int s = 0; s < 4; s++) begin
      wr(8'h1C, 32'(s) << 12);
      clear_irq();
      pulse((s + 1) % 4);
      pulse((s + 2) % 4);
      chk($sformatf("R9 sel %0d other phases ignored", s), 32'(irq_out), 0);
      pulse(s);
      chk($sformatf("R9 sel %0d picked phase", s), 32'(irq_out), 1);
      clear_irq();
    end
  endtask

  task automatic t_sticky();
    wr(8'h1C, 32'h0000_2000); // phase 2
    clear_irq();
    @(negedge clk); vphase[2] = 1'b1;
    repeat (4) @(negedge clk);
    vphase[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 held after phase drops", 32'(irq_out), 1);
    // clear while the level is held high: no re-arm
    vphase[2] = 1'b1;
    @(negedge clk);
    clear_irq();
    repeat (2) @(negedge clk);
    chk("R10 cleared, held level no re-arm", 32'(irq_out), 0);
    vphase[2] = 1'b0;
    @(negedge clk);
    // event and clear at the same edge
    vphase[2] = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0; vphase[2] = 1'b0; #1;
    chk("R10 set beats clear", 32'(irq_out), 1);
    irq_mask = 1'b0; #1;
    chk("R11 masked", 32'(irq_out), 0);
    irq_mask = 1'b1; #1;
    chk("R11 unmasked", 32'(irq_out), 1);
    clear_irq();
    chk("R10 clear", 32'(irq_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_reserved();
    t_addr();
    t_watermark();
    t_gate();
    t_test();
    t_power();
    t_select();
    t_sticky();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule